// File: doc/BRIEF.md
# Stack register file with bounds checking

This block is the operand store of a stack-style processing core. It holds up to `MAX_DEPTH` 32-bit entries and a count of how many are live. Instructions never name an absolute slot. Every operand is named by its distance below the current top of stack, so the slot an offset reaches moves as the stack grows and shrinks.

The core drives one operation per cycle:

- push a value;
- pop the top value;
- read an entry at an offset;
- overwrite an entry at an offset;
- binary combine: retire the two top entries and store an externally computed result as the new top.

Before any state changes, each operation is checked against the live count. A rejected operation leaves every entry, the count and the read data untouched. It raises a one-cycle error pulse with a code that separates overflow from underflow. The arithmetic itself and spilling entries to memory are outside this block.

Top module: `stack_regfile`

## Requirements
- R1: After reset (async, `rst_ni` low) `size_o` is 0, `err_valid_o` is 0, `err_code_o` is 2'b00 and `rdata_o` is 0.
- R2: Operation code 3'd1 (push) with `size_o` below `MAX_DEPTH` stores `wdata_i` as the new top, and `size_o` rises by one at the next edge.
- R3: Operation code 3'd3 (read) with `off_i` less than `size_o` places on `rdata_o`, one edge later, the entry `off_i` places below the top. Offset 0 is the top, and offset k is slot `size-1-k`.
- R4: A push while `size_o` equals `MAX_DEPTH` is an overflow. `err_code_o` becomes 2'b01, and the count and all entries stay unchanged.
- R5: Each of the following is an underflow: a pop at size 0, or a read or write whose `off_i` is not below `size_o`. `err_code_o` becomes 2'b10, and the count, entries and `rdata_o` stay unchanged.
- R6: Operation code 3'd4 (write) with `off_i` below `size_o` replaces the addressed entry with `wdata_i`. The count is unchanged.
- R7: Operation code 3'd2 (pop) with `size_o` of at least 1 places the top entry on `rdata_o` and lowers `size_o` by one, both at the next edge.
- R8: Operation code 3'd5 (binary combine) with `size_o` of at least 2 removes the two top entries and stores `wdata_i` as the new top, for a net count change of -1. With fewer than 2 entries it is an underflow.
- R9: The following have no effect and raise no error: operation code 3'd0, and the unused codes 3'd6 and 3'd7. `err_valid_o` is high for exactly the cycle after a rejected operation. `err_code_o` is 2'b00 whenever `err_valid_o` is low.
- R10: `size_o` never exceeds `MAX_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 idle, 1 push, 2 pop, 3 read, 4 write, 5 binary combine |
| off_i | input | SZ_W (4) | Operand offset below the top of stack |
| wdata_i | input | DATA_W (32) | Value for push, write and combine result |
| rdata_o | output | DATA_W (32) | Registered data from the last accepted read or pop |
| size_o | output | SZ_W (4) | Number of live entries |
| err_valid_o | output | 1 | One-cycle pulse for a rejected operation |
| err_code_o | output | 2 | 01 overflow, 10 underflow, 00 otherwise |

## Verification
The hardest states to reach are those at the full boundary. An overflow push, and offsets that land on the deepest live slot, both need the stack filled to exactly `MAX_DEPTH` through a run of accepted pushes. The bench does this first and then sweeps every offset from the top down to the bottom. It then walks offsets past the live count, including the largest encodable offset. Rejected writes and out-of-range reads are then followed by full readbacks, which prove that no slot was touched. A binary combine is issued both at size 1 and after mixed pops, to show that it is rejected below two entries.

// File: rtl/stack_rf_pkg.sv
package stack_rf_pkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_PUSH  = 3'd1;
  localparam logic [2:0] OP_POP   = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_WRITE = 3'd4;
  localparam logic [2:0] OP_BINOP = 3'd5;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_OVER  = 2'b01;
  localparam logic [1:0] ERR_UNDER = 2'b10;
endpackage

// File: rtl/stack_rf_check.sv
module stack_rf_check
  import stack_rf_pkg::*;
#(
  parameter int MAX_DEPTH = 8,
  parameter int SZ_W      = $clog2(MAX_DEPTH + 1),
  parameter int IDX_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic [2:0]       op_i,
  input  logic [SZ_W-1:0]  off_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [SZ_W-1:0]  size_nxt_o
);
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(MAX_DEPTH);
  localparam logic [SZ_W-1:0] ONE    = SZ_W'(1);
  localparam logic [SZ_W-1:0] TWO    = SZ_W'(2);

  logic [SZ_W-1:0] top_pos, off_pos, second_pos;
  logic            off_ok;

  assign top_pos    = size_i - ONE;
  assign second_pos = size_i - TWO;
  assign off_pos    = size_i - ONE - off_i;
  assign off_ok     = off_i < size_i;

  always_comb begin
    err_o      = 1'b0;
    err_code_o = ERR_NONE;
    wr_en_o    = 1'b0;
    wr_idx_o   = '0;
    rd_en_o    = 1'b0;
    rd_idx_o   = '0;
    size_nxt_o = size_i;
    unique case (op_i)
      OP_PUSH: begin
        if (size_i >= MAX_SZ) begin
          err_o      = 1'b1;
          err_code_o = ERR_OVER;
        end else begin
          wr_en_o    = 1'b1;
          wr_idx_o   = IDX_W'(size_i);
          size_nxt_o = size_i + ONE;
        end
      end
      OP_POP: begin
        if (size_i == '0) begin
          err_o      = 1'b1;
          err_code_o = ERR_UNDER;
        end else begin
          rd_en_o    = 1'b1;
          rd_idx_o   = IDX_W'(top_pos);
          size_nxt_o = top_pos;
        end
      end
      OP_READ: begin
        if (!off_ok) begin
          err_o      = 1'b1;
          err_code_o = ERR_UNDER;
        end else begin
          rd_en_o  = 1'b1;
          rd_idx_o = IDX_W'(off_pos);
        end
      end
      OP_WRITE: begin
        if (!off_ok) begin
          err_o      = 1'b1;
          err_code_o = ERR_UNDER;
        end else begin
          wr_en_o  = 1'b1;
          wr_idx_o = IDX_W'(off_pos);
        end
      end
      OP_BINOP: begin
        if (size_i < TWO) begin
          err_o      = 1'b1;
          err_code_o = ERR_UNDER;
        end else begin
          wr_en_o    = 1'b1;
          wr_idx_o   = IDX_W'(second_pos);
          size_nxt_o = top_pos;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_rf_store.sv
module stack_rf_store #(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 8,
  parameter int IDX_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [MAX_DEPTH];

  for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && widx_i == IDX_W'(i)) slot_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < MAX_DEPTH; j++) begin
      if (ridx_i == IDX_W'(j)) rdata_o = slot_q[j];
    end
  end
endmodule

// File: rtl/stack_regfile.sv
module stack_regfile
  import stack_rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 8,
  localparam int SZ_W     = $clog2(MAX_DEPTH + 1),
  localparam int IDX_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [SZ_W-1:0]   off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SZ_W-1:0]   size_o,
  output logic              err_valid_o,
  output logic [1:0]        err_code_o
);
  logic [SZ_W-1:0]   size_q, size_nxt;
  logic [DATA_W-1:0] rdata_q, slot_rd;
  logic              err_q, err_nxt;
  logic [1:0]        code_q, code_nxt;
  logic              wr_en, rd_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  stack_rf_check #(.MAX_DEPTH(MAX_DEPTH), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_check (
    .op_i       (op_i),
    .off_i      (off_i),
    .size_i     (size_q),
    .err_o      (err_nxt),
    .err_code_o (code_nxt),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .rd_en_o    (rd_en),
    .rd_idx_o   (rd_idx),
    .size_nxt_o (size_nxt)
  );

  stack_rf_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .widx_i  (wr_idx),
    .wdata_i (wdata_i),
    .ridx_i  (rd_idx),
    .rdata_o (slot_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      size_q <= size_nxt;
      err_q  <= err_nxt;
      code_q <= code_nxt;
      if (rd_en) rdata_q <= slot_rd;
    end
  end

  assign size_o      = size_q;
  assign rdata_o     = rdata_q;
  assign err_valid_o = err_q;
  assign err_code_o  = code_q;
endmodule

// File: rtl/stack_regfile_sva.sv
module stack_regfile_sva #(
  parameter int MAX_DEPTH = 8,
  localparam int SZ_W     = $clog2(MAX_DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      op_i,
  input logic [SZ_W-1:0] size_o,
  input logic            err_valid_o,
  input logic [1:0]      err_code_o
);
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(MAX_DEPTH);

  // R10
  size_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o <= MAX_SZ);

  // R9
  err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o ? (err_code_o == 2'b01 || err_code_o == 2'b10) : (err_code_o == 2'b00));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && size_o == MAX_SZ) |=> (err_valid_o && err_code_o == 2'b01 && size_o == MAX_SZ));

  // R5
  pop_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && size_o == '0) |=> (err_valid_o && err_code_o == 2'b10 && size_o == '0));

  // R2
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && size_o < MAX_SZ) |=> (!err_valid_o && size_o == SZ_W'($past(size_o) + 1'b1)));

  // R8
  binop_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && size_o >= SZ_W'(2)) |=> (!err_valid_o && size_o == SZ_W'($past(size_o) - 1'b1)));
endmodule

bind stack_regfile stack_regfile_sva #(.MAX_DEPTH(MAX_DEPTH)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .size_o      (size_o),
  .err_valid_o (err_valid_o),
  .err_code_o  (err_code_o)
);

// File: tb/stack_regfile_tb_top.sv
module stack_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int SZW        = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = 3'd0;
  logic [SZW-1:0]   off = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [SZW-1:0]   size;
  logic             err_v;
  logic [1:0]       err_c;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mdl [DEPTH];
  int          msize = 0;
  logic [31:0] mrd = '0;
  logic        merr = 1'b0;
  logic [1:0]  mcode = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_regfile #(.DATA_W(32), .MAX_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .off_i(off), .wdata_i(wdata),
    .rdata_o(rdata), .size_o(size), .err_valid_o(err_v), .err_code_o(err_c)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " size"},  32'(size),  32'(msize));
    chk({tag, " err"},   32'(err_v), 32'(merr));
    chk({tag, " code"},  32'(err_c), 32'(mcode));
    chk({tag, " rdata"}, rdata,      mrd);
  endtask

  // Drive one operation, update the spec model, compare one edge later.
  task automatic do_op(input string tag, input logic [2:0] o, input int k, input logic [31:0] d);
    @(negedge clk);
    op = o; off = SZW'(k); wdata = d;
    merr = 1'b0; mcode = 2'b00;
    case (o)
      3'd1: if (msize == DEPTH) begin merr = 1; mcode = 2'b01; end
            else begin mdl[msize] = d; msize++; end
      3'd2: if (msize == 0) begin merr = 1; mcode = 2'b10; end
            else begin mrd = mdl[msize-1]; msize--; end
      3'd3: if (k >= msize) begin merr = 1; mcode = 2'b10; end
            else mrd = mdl[msize-1-k];
      3'd4: if (k >= msize) begin merr = 1; mcode = 2'b10; end
            else mdl[msize-1-k] = d;
      3'd5: if (msize < 2) begin merr = 1; mcode = 2'b10; end
            else begin mdl[msize-2] = d; msize--; end
      default: ;
    endcase
    @(posedge clk); #1;
    op = 3'd0;
    chk_all(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    msize = 0; mrd = '0; merr = 0; mcode = 2'b00;
    chk_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all("R1 after release");
  endtask

  task automatic t_empty;
    do_op("R5 pop empty", 3'd2, 0, 0);
    do_op("R5 read empty", 3'd3, 0, 0);
    do_op("R8 binop empty", 3'd5, 0, 32'h55);
  endtask

  task automatic t_fill;
    for (int i = 0; i < DEPTH; i++) do_op("R2 push", 3'd1, 0, 32'hA000_0000 + 32'(i*17));
  endtask

  task automatic t_overflow;
    do_op("R4 push full", 3'd1, 0, 32'hDEAD_BEEF);
    do_op("R10 push full again", 3'd1, 0, 32'hDEAD_BEE0);
    do_op("R4 top intact", 3'd3, 0, 0);
  endtask

  task automatic t_offsets;
    for (int k = 0; k < DEPTH; k++) do_op("R3 read offset", 3'd3, k, 0);
    do_op("R5 read off=size", 3'd3, DEPTH, 0);
    do_op("R5 read off max", 3'd3, 15, 0);
  endtask

  task automatic t_write;
    do_op("R6 write off3", 3'd4, 3, 32'h1234_5678);
    do_op("R6 readback off3", 3'd3, 3, 0);
    do_op("R6 write top", 3'd4, 0, 32'hCAFE_0000);
    do_op("R5 write beyond", 3'd4, 9, 32'hBAD0_BAD0);
    for (int k = 0; k < DEPTH; k++) do_op("R5 no corruption", 3'd3, k, 0);
  endtask

  task automatic t_pulse;
    do_op("R5 read beyond", 3'd3, 12, 0);
    do_op("R9 pulse ends", 3'd0, 0, 0);
    do_op("R9 code 6 idle", 3'd6, 0, 32'hFFFF_FFFF);
    do_op("R9 code 7 idle", 3'd7, 2, 32'hFFFF_FFFF);
    do_op("R9 state kept", 3'd3, 0, 0);
  endtask

  task automatic t_pop;
    for (int i = 0; i < 3; i++) do_op("R7 pop", 3'd2, 0, 0);
  endtask

  task automatic t_binop;
    do_op("R8 binop", 3'd5, 0, 32'h0BB0_0001);
    do_op("R8 new top", 3'd3, 0, 0);
    do_op("R8 below kept", 3'd3, 1, 0);
    while (msize > 1) do_op("R7 drain", 3'd2, 0, 0);
    do_op("R8 binop size1", 3'd5, 0, 32'h77);
    do_op("R8 lone entry kept", 3'd3, 0, 0);
    do_op("R2 push after", 3'd1, 0, 32'h4242);
    do_op("R8 binop size2", 3'd5, 0, 32'h9999);
    do_op("R8 result top", 3'd2, 0, 0);
  endtask

  task automatic t_reset_mid;
    do_op("R2 push pre-reset", 3'd1, 0, 32'h1);
    do_op("R2 push pre-reset", 3'd1, 0, 32'h2);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_empty();
    t_fill();
    t_overflow();
    t_offsets();
    t_write();
    t_pulse();
    t_pop();
    t_binop();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule